// File: doc/BRIEF.md
# Top-Six Row/Column Channel Selector

This block reduces one detector event to its six strongest summed readouts. A crystal array is read out through summed row lines and summed column lines, 20 of each by default. Their integrated pulse heights arrive together, with a one-cycle event strobe. The block ranks the channels and hands on the six largest. The signals of one crystal pair come in groups of three, so six results cover both crystals of the pair.

Each result is a 16-bit word, ready to drop into a sensor field of an event record. The upper 5 bits hold the line number inside its group, and the lower 11 bits hold the saturated pulse height. A separate flag per result says whether the line is a column or a row.

The ranking is sequential. One channel per clock is inserted into a six-entry list that is kept sorted, so a result always takes the same number of cycles. While a search runs, the block raises `busy` and drops any new event strobe.

Top module: `topk_chan_picker`

## Requirements
- R1: After reset, `busy` and `done` are 0, and `sel_words` and `sel_is_col` are all zero.
- R2: An `evt_valid` sampled while `busy` is 0 is accepted. `busy` is 1 from the next cycle on. `done` pulses exactly 40 clock edges after the accepting edge, and in that cycle `busy` is 0 again.
- R3: The six reported channels are the six with the largest saturated values among the 40 inputs.
- R4: Channel c of the input bus occupies bits `[c*IN_W +: IN_W]`. Channels 0..19 are rows and 20..39 are columns. For each result slot k, `sel_words[16k+15:16k+11]` holds the index within the group (c or c-20), `sel_words[16k+10:16k]` holds the value, and `sel_is_col[k]` is 1 for a column.
- R5: An input value above 2047 is reported as 2047 and ranked as 2047.
- R6: Slot 0 holds the largest value, and the values do not increase from slot k to slot k+1.
- R7: When two values are equal, the channel with the lower index takes the earlier slot.
- R8: An `evt_valid` that arrives while `busy` is 1 is ignored. The result reported next belongs to the event that was accepted.
- R9: `sel_words` and `sel_is_col` change only in a cycle where `done` is 1, and they hold their value until the next `done`.
- R10: `done` is high for exactly one cycle per accepted event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | One-cycle strobe: the channel values are present |
| evt_vals | input | (N_ROW+N_COL)*IN_W | Integrated values, channel c at `[c*IN_W +: IN_W]` |
| busy | output | 1 | A search is in progress; new strobes are dropped |
| done | output | 1 | One-cycle pulse: the results have just been updated |
| sel_words | output | K*16 | Packed results, slot k at `[16k +: 16]` |
| sel_is_col | output | K | Per slot: 1 for a column line, 0 for a row line |

## Verification
The bench builds the block with its default parameters: 20 rows, 20 columns, six results and 14-bit inputs. Because the input is 14 bits wide, values far above the 11-bit output ceiling can be driven, so saturation and ranking among saturated values can both be reached. Forty channels give searches long enough for a second strobe to land in the middle of a run. Equal-value patterns make the tie order visible in the output slots.

// File: rtl/topk_pkg.sv
package topk_pkg;
    // Fixed layout of one result word: position code on top, value below.
    localparam int VAL_W  = 11;
    localparam int POS_W  = 5;
    localparam int WORD_W = POS_W + VAL_W;
    localparam int CH_W   = 6;
    localparam logic [VAL_W-1:0] VAL_MAX = '1;

    // One entry of the sorted candidate list.
    typedef struct packed {
        logic             vld;
        logic [VAL_W-1:0] val;
        logic [CH_W-1:0]  ch;
    } slot_t;
endpackage

// File: rtl/topk_clamp.sv
module topk_clamp
    import topk_pkg::*;
#(
    parameter int IN_W = 14
) (
    input  logic [IN_W-1:0]  raw,
    output logic [VAL_W-1:0] sat
);
    generate
        if (IN_W > VAL_W) begin : g_wide
            always_comb begin
                if (raw > IN_W'(VAL_MAX)) sat = VAL_MAX;
                else                      sat = raw[VAL_W-1:0];
            end
        end else begin : g_narrow
            assign sat = VAL_W'(raw);
        end
    endgenerate
endmodule

// File: rtl/topk_insert.sv
module topk_insert
    import topk_pkg::*;
#(
    parameter int K = 6
) (
    input  slot_t [K-1:0]    cur,
    input  logic [VAL_W-1:0] cand_val,
    input  logic [CH_W-1:0]  cand_ch,
    output slot_t [K-1:0]    nxt
);
    // Candidate beats an entry only if strictly larger, so earlier
    // (lower-index) channels keep their place on equal values.
    logic [K-1:0] ahead;
    slot_t        cand;

    assign cand = '{vld: 1'b1, val: cand_val, ch: cand_ch};

    genvar i;
    generate
        for (i = 0; i < K; i++) begin : g_slot
            assign ahead[i] = !cur[i].vld || (cand_val > cur[i].val);
            if (i == 0) begin : g_head
                assign nxt[i] = ahead[i] ? cand : cur[i];
            end else begin : g_tail
                assign nxt[i] = !ahead[i]    ? cur[i]   :
                                ahead[i-1]   ? cur[i-1] : cand;
            end
        end
    endgenerate
endmodule

// File: rtl/topk_chan_picker.sv
module topk_chan_picker
    import topk_pkg::*;
#(
    parameter int N_ROW = 20,
    parameter int N_COL = 20,
    parameter int K     = 6,
    parameter int IN_W  = 14
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          evt_valid,
    input  logic [(N_ROW+N_COL)*IN_W-1:0] evt_vals,
    output logic                          busy,
    output logic                          done,
    output logic [K*WORD_W-1:0]           sel_words,
    output logic [K-1:0]                  sel_is_col
);
    localparam int N_CH = N_ROW + N_COL;
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(N_CH - 1);
    localparam logic [CH_W-1:0] ROW_CNT = CH_W'(N_ROW);

    typedef struct packed {
        logic                   busy;
        logic                   done;
        logic [CH_W-1:0]        idx;
        slot_t [K-1:0]          list;
        logic [N_CH*IN_W-1:0]   vals;
        logic [K*WORD_W-1:0]    words;
        logic [K-1:0]           is_col;
    } state_t;

    state_t st_d, st_q;

    logic [IN_W-1:0]  raw_cur;
    logic [VAL_W-1:0] sat_cur;
    slot_t [K-1:0]    ins_list;

    assign raw_cur = st_q.vals[int'(st_q.idx)*IN_W +: IN_W];

    topk_clamp #(.IN_W(IN_W)) clamp_i (
        .raw (raw_cur),
        .sat (sat_cur)
    );

    topk_insert #(.K(K)) insert_i (
        .cur      (st_q.list),
        .cand_val (sat_cur),
        .cand_ch  (st_q.idx),
        .nxt      (ins_list)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (evt_valid) begin
                st_d.busy = 1'b1;
                st_d.idx  = '0;
                st_d.list = '0;
                st_d.vals = evt_vals;
            end
        end else begin
            st_d.list = ins_list;
            if (st_q.idx == LAST_CH) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                for (int k = 0; k < K; k++) begin
                    if (ins_list[k].ch >= ROW_CNT) begin
                        st_d.is_col[k] = 1'b1;
                        st_d.words[k*WORD_W +: WORD_W] =
                            {POS_W'(ins_list[k].ch - ROW_CNT), ins_list[k].val};
                    end else begin
                        st_d.is_col[k] = 1'b0;
                        st_d.words[k*WORD_W +: WORD_W] =
                            {POS_W'(ins_list[k].ch), ins_list[k].val};
                    end
                end
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy       = st_q.busy;
    assign done       = st_q.done;
    assign sel_words  = st_q.words;
    assign sel_is_col = st_q.is_col;

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !busy) |=> busy);

    // R2
    scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st_q.idx != LAST_CH) |=> (busy && st_q.idx == $past(st_q.idx) + 1'b1));

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> (done || ($stable(sel_words) && $stable(sel_is_col))));

    genvar g;
    generate
        for (g = 1; g < K; g++) begin : g_order
            // R6
            desc_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
                done |-> (sel_words[g*WORD_W +: VAL_W] <= sel_words[(g-1)*WORD_W +: VAL_W]));
        end
    endgenerate
endmodule

// File: tb/topk_chan_picker_tb.sv
module topk_chan_picker_tb_top;
    localparam int NR = 20, NC = 20, NK = 6, IW = 14, NCH = NR + NC;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  evt_valid = 1'b0;
    logic [NCH*IW-1:0]     evt_vals = '0;
    logic                  busy, done;
    logic [NK*16-1:0]      sel_words;
    logic [NK-1:0]         sel_is_col;

    int checks = 0, errors = 0, cycles = 0;
    string cur_tag = "R3";

    // Reference model state
    bit busy_m = 0, done_m = 0;
    int cnt_m = 0;
    int pend_w[NK], pend_c[NK], out_w[NK], out_c[NK];

    topk_chan_picker #(.N_ROW(NR), .N_COL(NC), .K(NK), .IN_W(IW)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_vals(evt_vals),
        .busy(busy), .done(done), .sel_words(sel_words), .sel_is_col(sel_is_col)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic predict();
        int v[NCH];
        bit taken[NCH];
        for (int c = 0; c < NCH; c++) begin
            v[c] = int'(evt_vals[c*IW +: IW]);
            if (v[c] > 2047) v[c] = 2047;
            taken[c] = 0;
        end
        for (int k = 0; k < NK; k++) begin
            int best = -1;
            for (int c = 0; c < NCH; c++)
                if (!taken[c] && (best < 0 || v[c] > v[best])) best = c;
            taken[best] = 1;
            pend_c[k] = (best >= NR) ? 1 : 0;
            pend_w[k] = (((best >= NR) ? best - NR : best) << 11) | v[best];
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (!rst_n) begin
            busy_m = 0; done_m = 0; cnt_m = 0;
            for (int k = 0; k < NK; k++) begin out_w[k] = 0; out_c[k] = 0; end
            chk("R1 busy", int'(busy), 0);
            chk("R1 done", int'(done), 0);
            chk("R1 words", int'(sel_words != '0), 0);
            chk("R1 flags", int'(sel_is_col), 0);
        end else begin
            chk("R2 busy", int'(busy), int'(busy_m));
            chk("R10 done", int'(done), int'(done_m));
            for (int k = 0; k < NK; k++) begin
                if (done_m) begin
                    chk({cur_tag, " word"}, int'(sel_words[k*16 +: 16]), out_w[k]);
                    chk("R4 column flag", int'(sel_is_col[k]), out_c[k]);
                end else begin
                    chk("R9 hold", int'(sel_words[k*16 +: 16]), out_w[k]);
                end
            end
            done_m = 0;
            if (!busy_m) begin
                if (evt_valid) begin busy_m = 1; cnt_m = 0; predict(); end
            end else begin
                cnt_m++;
                if (cnt_m == NCH) begin
                    busy_m = 0; done_m = 1;
                    for (int k = 0; k < NK; k++) begin out_w[k] = pend_w[k]; out_c[k] = pend_c[k]; end
                end
            end
        end
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic send(input int v[NCH]);
        @(posedge clk); #2;
        for (int c = 0; c < NCH; c++) evt_vals[c*IW +: IW] = IW'(v[c]);
        evt_valid = 1'b1;
        @(posedge clk); #2;
        evt_valid = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    initial begin
        int v[NCH];
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R3: random in-range values
        cur_tag = "R3";
        for (int n = 0; n < 4; n++) begin
            for (int c = 0; c < NCH; c++) v[c] = $urandom_range(0, 2047);
            send(v); wait_done();
        end

        // R5: full-width values, many saturate
        cur_tag = "R5";
        for (int n = 0; n < 2; n++) begin
            for (int c = 0; c < NCH; c++) v[c] = $urandom_range(0, 16383);
            send(v); wait_done();
        end

        // R6: ramp, the top is in the column group
        cur_tag = "R6";
        for (int c = 0; c < NCH; c++) v[c] = c * 50;
        send(v); wait_done();

        // R7: equal values everywhere, plus a tie pair across groups
        cur_tag = "R7";
        for (int c = 0; c < NCH; c++) v[c] = 1000;
        v[3] = 1500; v[25] = 1500; v[30] = 3000; v[8] = 2047;
        send(v); wait_done();

        // R8: a second strobe mid-search is dropped
        cur_tag = "R8";
        for (int c = 0; c < NCH; c++) v[c] = 100 + c;
        send(v);
        repeat (8) @(posedge clk);
        for (int c = 0; c < NCH; c++) v[c] = 2000 - c;
        #2;
        for (int c = 0; c < NCH; c++) evt_vals[c*IW +: IW] = IW'(v[c]);
        evt_valid = 1'b1;
        @(posedge clk); #2 evt_valid = 1'b0;
        wait_done();

        repeat (4) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule